// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

The engine turns an asynchronous serial line into bytes. An external 16x sample tick paces it. Each character opens with a low start bit, and the engine finds that bit by watching for a falling edge on the idle-high line. The first data bit comes next. The data bits are sent least significant first and are followed by an optional parity bit and one or two high stop bits. The engine samples each bit near its middle. It therefore needs no alignment from one character to the next: the gap between characters may be any length, and only the bit spacing inside a character is fixed.

Each completed character is placed in a holding register, and a ready flag is raised. The host collects the byte with a data-read strobe, which drops the ready flag. Four error conditions are kept as separate flags: a byte lost to overrun, a parity mismatch, a bad stop bit, and a line held low for a whole character (break). Each error flag stays set until the host pulses an error-read strobe.

A self-test control swaps the external receive pin for the local transmit line. This lets transmitter and receiver be exercised back to back with nothing attached to the pin.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, `rx_ready` is 0, `rx_byte` is 0, and all four error flags are 0.
- R2: The engine recognises a frame built as follows:
  - one low start bit;
  - 5 + `cfg_len` data bits, least significant first (`cfg_len` 0..3 gives 5..8 bits);
  - a parity bit, present when `cfg_par_en` is 1;
  - one stop bit, or two when `cfg_two_stop` is 1.

  Once the last stop bit has been sampled, the data bits appear in `rx_byte`, right-aligned, with the unused upper bits at 0, and `rx_ready` becomes 1.
- R3: A low pulse is ignored and produces no byte when the line is high again at the 8th tick after the falling edge was seen.
- R4: A pulse on `rd_byte` clears `rx_ready`. When a new byte is stored in the same cycle, the store wins and `rx_ready` stays 1.
- R5: When a byte completes while `rx_ready` is still 1 and no read arrives in that cycle, `err_overrun` is set and the newer byte replaces the older one.
- R6: With `cfg_par_odd` = 0, the data bits and the parity bit together must contain an even number of ones; with `cfg_par_odd` = 1, an odd number. On a mismatch `err_parity` is set, and the byte is still delivered.
- R7: A stop bit sampled low sets `err_frame`, and the byte is still delivered. With two stop bits, both are checked.
- R8: When every sample of a frame is low (data, parity and stop bits), the engine sets `err_break` and `err_frame`. It leaves `err_parity` alone, stores no byte and leaves `rx_ready` unchanged. A new frame starts only after the line has been high again.
- R9: The error flags are sticky. `rd_byte` does not clear them. A pulse on `rd_err` clears all four, except that a flag being set in the same cycle stays set.
- R10: When `loopback` is 1, the engine receives `tx_line`, and `rx_pin` has no effect.
- R11: Sampling advances only on cycles where `tick` is 1. One bit lasts 16 ticks, and without ticks no frame is ever received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampling enable, one cycle wide |
| rx_pin | input | 1 | External serial input, idle high |
| tx_line | input | 1 | Local transmit line, used in self-test |
| loopback | input | 1 | 1 selects `tx_line` as the receive source |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 for two stop bits |
| rd_byte | input | 1 | Read strobe for the holding register |
| rd_err | input | 1 | Read strobe for the error flags, clears them |
| rx_byte | output | 8 | Received byte, right-aligned |
| rx_ready | output | 1 | Holding register has an unread byte |
| err_overrun | output | 1 | A byte arrived before the previous one was read |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled low |
| err_break | output | 1 | Whole frame sampled low |

## Verification
The hardest case to reach is a break that does not end at the stop sample. The line has to stay low past the stop position, and the engine must then refuse to treat that continuing low level as a new start bit. The stimulus holds `rx_pin` low for twelve bit times with odd parity configured, so an all-zero character would also fail the parity check. The bench then expects break and frame error together, no parity error and no byte. A further clean frame shows that the engine re-arms only on a fresh falling edge. The main sweep covers every combination of word length, parity mode and stop count with several data patterns, and predicts the masked byte arithmetically.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic done;
        logic brk;
        logic perr;
        logic ferr;
    } rx_event_t;

endpackage

// File: rtl/serial_rx_linesel.sv
module serial_rx_linesel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic tx_line,
    input  logic loopback,
    output logic line
);
    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SW-1:0] sync_d, sync_q;
    logic          src;

    always_comb begin
        src    = loopback ? tx_line : rx_pin;
        sync_d = {sync_q[SW-2:0], src};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line = sync_q[SW-1];

endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import serial_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MAX_BITS = 8,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    output rx_event_t           evt,
    output logic [MAX_BITS-1:0] evt_data
);
    localparam int CNT_W = $clog2(OVS);
    localparam int MID   = OVS / 2;
    localparam int IDX_W = $clog2(MAX_BITS);

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] sh;
        logic                prev;
        logic                par;
        logic                seen;
        logic                stop2;
        logic                serr;
        rx_event_t           evt;
        logic [MAX_BITS-1:0] data;
    } deser_t;

    deser_t           d, q;
    logic [IDX_W-1:0] last_bit;
    logic [IDX_W:0]   shamt;
    logic             bit_end;
    logic             any_one;

    always_comb begin
        last_bit = IDX_W'(MIN_BITS - 1 + int'(cfg_len));
        shamt    = (IDX_W+1)'(MAX_BITS - MIN_BITS - int'(cfg_len));
        bit_end  = (q.cnt == CNT_W'(OVS - 1));
        any_one  = q.seen | line;
        d        = q;
        d.evt    = '0;
        if (tick) begin
            d.prev = line;
            d.cnt  = q.cnt + 1'b1;
            unique case (q.st)
                ST_IDLE: begin
                    d.cnt = '0;
                    if (q.prev && !line) d.st = ST_START;
                end
                ST_START: begin
                    if (q.cnt == CNT_W'(MID - 1)) begin
                        d.cnt = '0;
                        if (line) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st    = ST_DATA;
                            d.idx   = '0;
                            d.par   = 1'b0;
                            d.seen  = 1'b0;
                            d.stop2 = 1'b0;
                            d.serr  = 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.sh   = {line, q.sh[MAX_BITS-1:1]};
                        d.par  = q.par ^ line;
                        d.seen = any_one;
                        d.idx  = q.idx + 1'b1;
                        if (q.idx == last_bit) d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.par  = q.par ^ line;
                        d.seen = any_one;
                        d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        d.cnt = '0;
                        if (cfg_two_stop && !q.stop2) begin
                            d.stop2 = 1'b1;
                            d.serr  = !line;
                            d.seen  = any_one;
                        end else begin
                            d.st       = ST_IDLE;
                            d.evt.done = 1'b1;
                            d.evt.brk  = !any_one;
                            d.evt.ferr = q.serr | !line;
                            d.evt.perr = cfg_par_en && (q.par != cfg_par_odd) && any_one;
                            d.data     = q.sh >> shamt;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign evt      = q.evt;
    assign evt_data = q.data;

    // R11: without a tick the sampler does not move
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(q.st) && $stable(q.cnt)));

    // R3: a start bit found high again at its middle is dropped
    a_r3_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && tick && q.cnt == CNT_W'(MID - 1) && line)
        |=> (q.st == ST_IDLE && !q.evt.done));

    // R8: a break event always carries a frame error and never a parity error
    a_r8_break_is_frame_error: assert property (@(posedge clk) disable iff (!rst_n)
        (q.evt.done && q.evt.brk) |-> (q.evt.ferr && !q.evt.perr));

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_rx_pkg::*;
#(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rx_event_t           evt,
    input  logic [MAX_BITS-1:0] evt_data,
    input  logic                rd_byte,
    input  logic                rd_err,
    output logic [MAX_BITS-1:0] rx_byte,
    output logic                rx_ready,
    output logic                err_overrun,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_break
);
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                rdy;
        logic                ovr;
        logic                par;
        logic                frm;
        logic                brk;
    } hold_t;

    hold_t d, q;
    logic  load;

    always_comb begin
        load  = evt.done && !evt.brk;
        d     = q;
        d.data = load ? evt_data : q.data;
        d.rdy  = load | (q.rdy & !rd_byte);
        d.ovr  = (load & q.rdy & !rd_byte) | (q.ovr & !rd_err);
        d.par  = (load & evt.perr) | (q.par & !rd_err);
        d.frm  = (evt.done & (evt.ferr | evt.brk)) | (q.frm & !rd_err);
        d.brk  = (evt.done & evt.brk) | (q.brk & !rd_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte     = q.data;
    assign rx_ready    = q.rdy;
    assign err_overrun = q.ovr;
    assign err_parity  = q.par;
    assign err_frame   = q.frm;
    assign err_break   = q.brk;

    // R2: a completed byte is presented with the ready flag
    a_r2_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.rdy && q.data == $past(evt_data)));

    // R4: a read with no new byte empties the holding register
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte && !evt.done) |=> !q.rdy);

    // R5: an unread byte overwritten raises overrun
    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && q.rdy && !rd_byte) |=> q.ovr);

    // R9: flags survive until the error read
    a_r9_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_err |=> ((!$past(q.ovr) || q.ovr) && (!$past(q.par) || q.par) &&
                     (!$past(q.frm) || q.frm) && (!$past(q.brk) || q.brk)));

    // R8: a break leaves the holding register untouched
    a_r8_break_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.done && evt.brk) |=> $stable(q.data));

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
    import serial_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int MAX_BITS    = 8,
    parameter int MIN_BITS    = 5,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx_pin,
    input  logic                tx_line,
    input  logic                loopback,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                rd_byte,
    input  logic                rd_err,
    output logic [MAX_BITS-1:0] rx_byte,
    output logic                rx_ready,
    output logic                err_overrun,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_break
);
    logic                line;
    rx_event_t           evt;
    logic [MAX_BITS-1:0] evt_data;

    serial_rx_linesel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pin   (rx_pin),
        .tx_line  (tx_line),
        .loopback (loopback),
        .line     (line)
    );

    serial_rx_deser #(
        .OVS(OVS), .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)
    ) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .line         (line),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .evt          (evt),
        .evt_data     (evt_data)
    );

    serial_rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .evt_data    (evt_data),
        .rd_byte     (rd_byte),
        .rd_err      (rd_err),
        .rx_byte     (rx_byte),
        .rx_ready    (rx_ready),
        .err_overrun (err_overrun),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_break   (err_break)
    );

endmodule

// File: tb/serial_rx_engine_tb.sv
module serial_rx_engine_tb;
    localparam int BIT_CYC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_en = 1'b1;
    logic       rx_pin = 1'b1;
    logic       tx_line = 1'b1;
    logic       loopback = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd_byte = 1'b0;
    logic       rd_err = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_ready, err_overrun, err_parity, err_frame, err_break;
    logic       use_tx = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= tick_en ? ~tick : 1'b0;

    serial_rx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pin(rx_pin), .tx_line(tx_line),
        .loopback(loopback), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .rd_byte(rd_byte),
        .rd_err(rd_err), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] flags();
        return {err_overrun, err_parity, err_frame, err_break};
    endfunction

    task automatic put(input logic b, input int nbits);
        if (use_tx) tx_line = b; else rx_pin = b;
        repeat (BIT_CYC * nbits) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v, input bit bad_par, input bit bad_stop);
        int  n;
        logic p;
        n = 5 + int'(cfg_len);
        p = cfg_par_odd;
        put(1'b1, 1);
        put(1'b0, 1);
        for (int i = 0; i < n; i++) begin
            put(v[i], 1);
            p = p ^ v[i];
        end
        if (cfg_par_en) put(p ^ bad_par, 1);
        if (cfg_two_stop) begin
            put(1'b1, 1);
            put(!bad_stop, 1);
        end else begin
            put(!bad_stop, 1);
        end
        put(1'b1, 2);
    endtask

    task automatic pulse_rd();
        rd_byte = 1'b1; @(negedge clk); rd_byte = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_err();
        rd_err = 1'b1; @(negedge clk); rd_err = 1'b0; @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] pats [5] = '{8'h5A, 8'hA5, 8'hFF, 8'h01, 8'hC3};
        logic [7:0] exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", rx_ready, 0);
        chk("R1 byte", rx_byte, 0);
        chk("R1 flags", flags(), 0);

        // R2 R6 R7 sweep over all formats
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 5; k++) begin
                        cfg_len = 2'(l);
                        cfg_par_en = (pm != 0);
                        cfg_par_odd = (pm == 2);
                        cfg_two_stop = s[0];
                        send(pats[k], 1'b0, 1'b0);
                        exp = pats[k] & 8'((1 << (5 + l)) - 1);
                        chk("R2 byte", rx_byte, exp);
                        chk("R2 ready", rx_ready, 1);
                        chk("R6 R7 no errors", flags(), 0);
                        pulse_rd();
                        chk("R4 read clears ready", rx_ready, 0);
                    end
                end
            end
        end

        // R6 parity mismatch, even and odd
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        send(8'h37, 1'b1, 1'b0);
        chk("R6 even mismatch flag", flags(), 4'b0100);
        chk("R6 byte still delivered", rx_byte, 8'h37);
        pulse_rd();
        // R9 flag survives a byte read and a clean frame
        chk("R9 survives rd_byte", err_parity, 1);
        send(8'h11, 1'b0, 1'b0);
        chk("R9 survives good frame", err_parity, 1);
        pulse_rd();
        pulse_err();
        chk("R9 rd_err clears", flags(), 0);
        cfg_par_odd = 1'b1;
        send(8'h80, 1'b1, 1'b0);
        chk("R6 odd mismatch flag", err_parity, 1);
        pulse_rd(); pulse_err();

        // R7 stop errors
        cfg_par_en = 1'b0;
        send(8'h6E, 1'b0, 1'b1);
        chk("R7 bad stop flag", flags(), 4'b0010);
        chk("R7 byte delivered", rx_byte, 8'h6E);
        pulse_rd(); pulse_err();
        cfg_two_stop = 1'b1;
        send(8'h9C, 1'b0, 1'b1);
        chk("R7 bad second stop", err_frame, 1);
        pulse_rd(); pulse_err();
        cfg_two_stop = 1'b0;

        // R5 overrun
        send(8'h21, 1'b0, 1'b0);
        send(8'h42, 1'b0, 1'b0);
        chk("R5 overrun flag", flags(), 4'b1000);
        chk("R5 newest byte kept", rx_byte, 8'h42);
        pulse_rd();
        chk("R9 overrun survives rd_byte", err_overrun, 1);
        pulse_err();
        chk("R9 overrun cleared", err_overrun, 0);

        // R3 start glitch
        rx_pin = 1'b0;
        repeat (12) @(negedge clk);
        rx_pin = 1'b1;
        repeat (BIT_CYC * 12) @(negedge clk);
        chk("R3 glitch no byte", rx_ready, 0);
        chk("R3 glitch no flags", flags(), 0);
        send(8'hE7, 1'b0, 1'b0);
        chk("R3 next frame byte", rx_byte, 8'hE7);
        pulse_rd();

        // R8 break with odd parity configured
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        put(1'b0, 12);
        chk("R8 break flags", flags(), 4'b0011);
        chk("R8 no byte stored", rx_ready, 0);
        chk("R8 holding unchanged", rx_byte, 8'hE7);
        put(1'b1, 2);
        chk("R8 no frame from held low", rx_ready, 0);
        pulse_err();
        send(8'h3D, 1'b0, 1'b0);
        chk("R8 recovers after line high", rx_byte, 8'h3D);
        chk("R8 recovered ready", rx_ready, 1);
        chk("R8 recovered no flags", flags(), 0);
        pulse_rd();
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R10 loopback: pin held low, data comes from tx_line
        loopback = 1'b1;
        use_tx = 1'b1;
        repeat (8) @(negedge clk);
        rx_pin = 1'b0;
        send(8'hB4, 1'b0, 1'b0);
        chk("R10 loopback byte", rx_byte, 8'hB4);
        chk("R10 pin ignored no flags", flags(), 0);
        pulse_rd();
        rx_pin = 1'b1;
        repeat (8) @(negedge clk);
        loopback = 1'b0;
        use_tx = 1'b0;
        tx_line = 1'b0;
        send(8'h5C, 1'b0, 1'b0);
        chk("R10 tx_line ignored when off", rx_byte, 8'h5C);
        pulse_rd();
        tx_line = 1'b1;

        // R11 no ticks, no reception
        tick_en = 1'b0;
        send(8'h77, 1'b0, 1'b0);
        chk("R11 no tick no byte", rx_ready, 0);
        tick_en = 1'b1;
        repeat (BIT_CYC) @(negedge clk);
        send(8'h78, 1'b0, 1'b0);
        chk("R11 ticks resume", rx_byte, 8'h78);

        done = 1'b1;
        summary();
    end
endmodule